// File: doc/BRIEF.md
# Converter Serial Readout Sequencer

This block is the digital sequencer behind the output port of a delta-sigma converter. It starts a conversion and waits for a completion strobe from the converter. It then keeps the finished result in a static shift register until a host asks for it. The host reads the result through a three-wire port made of an active-low chip select, a serial clock that the host drives, and a three-state serial data pin.

No configuration is written. Chip-select timing alone selects what happens:

- If chip select is dropped and raised again with no clock edge in between, the result is kept and the block stays idle.
- If chip select is dropped and raised after at least one rising clock edge, the readout is abandoned and a new conversion starts.
- If chip select stays low for a complete 24-bit frame, the readout ends and a new conversion starts.

While chip select is low and no frame is being shifted, the data pin shows whether a conversion is still running.

Chip select and the serial clock are brought into the system clock domain through synchronisers with edge detection. The block issues a conversion-start pulse on reset and again each time it re-enters the converting phase.

Top module: `sdo_readout_port`

## Requirements
- R1: After reset the block is converting. `conv_start` is high for exactly one system clock within the first two cycles after reset is released, and `sdo` reads 1 whenever chip select is low in this phase.
- R2: `sdo_oe` is 0 whenever the synchronised chip select is high, so the data pin is released. It is 1 when chip select is low.
- R3: While converting, with chip select low, `sdo` is 1. When a readout is ended, the block returns to converting and shows 1 again on `sdo`.
- R4: A `conv_done` pulse while converting captures `conv_sign` and `conv_result` and moves the block to the idle phase. A `conv_done` pulse in any other phase has no effect on the held frame.
- R5: The frame is 24 bits, sent most significant first. Bit 23 is a status bit equal to 0, bit 22 is 0, bit 21 is the sign (1 for a positive input), and bits 20..0 are the result. Bits 21 and 20 both at 1 mark an input above positive full scale.
- R6: The data pin moves to the next frame bit only on a falling serial-clock edge that follows a rising edge within the same readout. It stays steady across each rising edge.
- R7: After the 24th rising serial-clock edge of a readout, the block returns to converting and pulses `conv_start`.
- R8: If chip select rises before the first rising clock edge of a readout, the block returns to idle. No `conv_start` is issued, and a later readout delivers the same frame from its first bit.
- R9: If chip select rises after one or more rising clock edges of a readout, the readout is abandoned and a new conversion starts with a `conv_start` pulse.
- R10: `conv_start` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sck | input | 1 | Host serial clock, asynchronous |
| conv_done | input | 1 | One-cycle strobe from the converter: result is ready |
| conv_sign | input | 1 | Sign of the finished conversion, 1 for positive |
| conv_result | input | 21 | Magnitude bits of the finished conversion |
| conv_start | output | 1 | One-cycle pulse requesting a new conversion |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Output enable for the three-state data pin |

## Verification
The bench aims at the two chip-select aborts, because they look alike at the pins.

- If the abort before any clock edge restarted a conversion, the extra start pulse would be counted. The repeated readout would then show a busy status bit instead of the old frame.
- If the abort after some clock edges parked the block, the start count would not advance and the status would read 0.

Two more cases are checked:

- A completion strobe that arrives while the block is idle must not overwrite the held frame. A design that reloaded on it would deliver the wrong data on the next read.
- Each bit is sampled just before the rising clock edge and again a few cycles after it. A design that shifted on the rising edge would skip bits, and the scoreboard would flag it.

// File: rtl/sdo_port_pkg.sv
package sdo_port_pkg;

  localparam int RES_W   = 21;
  localparam int HDR_W   = 3;
  localparam int FRAME_W = RES_W + HDR_W;

  typedef enum logic [1:0] {
    PH_CONV  = 2'd0,
    PH_SLEEP = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;

  // Status bit (low = done), dummy zero, sign, then magnitude.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic sign,
                                                    input logic [RES_W-1:0] res);
    pack_frame = {1'b0, 1'b0, sign, res};
  endfunction

  function automatic logic above_full_scale(input logic [FRAME_W-1:0] f);
    above_full_scale = f[RES_W] & f[RES_W-1];
  endfunction

endpackage

// File: rtl/sdo_sync_edge.sv
module sdo_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic chain [STAGES];
  logic last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign level_o = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_VAL;
    else        last_q <= level_o;
  end

  assign rise_o = level_o & ~last_q;
  assign fall_o = ~level_o & last_q;

endmodule

// File: rtl/sdo_frame_shifter.sv
module sdo_frame_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  output logic         msb_o
);

  logic [W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (load_i)  sreg <= frame_i;
    else if (shift_i) sreg <= {sreg[W-2:0], 1'b0};
  end

  assign msb_o = sreg[W-1];

  // R5: a load places the presented frame in the register
  p_load_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sreg == $past(frame_i)));

  // R6 / R4: without a load or a shift request the frame is frozen
  p_hold_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sreg));

endmodule

// File: rtl/sdo_seq_fsm.sv
module sdo_seq_fsm
  import sdo_port_pkg::*;
#(
  parameter int BITS = FRAME_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_hi,
  input  logic   sck_rise,
  input  logic   sck_fall,
  input  logic   conv_done,
  output phase_e phase_o,
  output logic   load_o,
  output logic   shift_o,
  output logic   start_o
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             boot_q;

  // Named events for the assertions and the next-state logic
  logic armed;
  logic ev_capture, ev_enter, ev_park, ev_abort, ev_full, ev_count;

  assign armed      = (cnt_q != '0) || sck_rise;
  assign ev_capture = (ph_q == PH_CONV)  && conv_done;
  assign ev_enter   = (ph_q == PH_SLEEP) && !cs_hi;
  assign ev_park    = (ph_q == PH_SHIFT) && cs_hi && !armed;
  assign ev_abort   = (ph_q == PH_SHIFT) && cs_hi && armed;
  assign ev_full    = (ph_q == PH_SHIFT) && !cs_hi && sck_rise && (cnt_q == LAST);
  assign ev_count   = (ph_q == PH_SHIFT) && !cs_hi && sck_rise && (cnt_q != LAST);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    start_d = !boot_q;
    if (ev_capture) ph_d = PH_SLEEP;
    if (ev_enter) begin
      ph_d  = PH_SHIFT;
      cnt_d = '0;
    end
    if (ev_park) begin
      ph_d  = PH_SLEEP;
      cnt_d = '0;
    end
    if (ev_abort || ev_full) begin
      ph_d    = PH_CONV;
      cnt_d   = '0;
      start_d = 1'b1;
    end
    if (ev_count) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_CONV;
      cnt_q   <= '0;
      start_q <= 1'b0;
      boot_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      boot_q  <= 1'b1;
    end
  end

  assign phase_o = ph_q;
  assign load_o  = ev_capture;
  assign shift_o = (ph_q == PH_SHIFT) && !cs_hi && sck_fall && (cnt_q != '0);
  assign start_o = start_q;

  p_boot_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> (start_q && ph_q == PH_CONV));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> (ph_q == PH_SLEEP));

  p_done_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SLEEP && conv_done && cs_hi) |=> (ph_q == PH_SLEEP && !load_o));

  p_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |=> (ph_q == PH_CONV && start_q));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SHIFT) |-> (cnt_q <= LAST));

  p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_park |=> (ph_q == PH_SLEEP && !start_q));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (ph_q == PH_CONV && start_q));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

endmodule

// File: rtl/sdo_readout_port.sv
module sdo_readout_port
  import sdo_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             conv_done,
  input  logic             conv_sign,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_start,
  output logic             sdo,
  output logic             sdo_oe
);

  logic   cs_hi, cs_rise_unused, cs_fall_unused;
  logic   sck_lvl_unused, sck_rise, sck_fall;
  phase_e phase;
  logic   load, shift, frame_msb;
  logic   over_fs_unused;

  sdo_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cs_n),
    .level_o (cs_hi),
    .rise_o  (cs_rise_unused),
    .fall_o  (cs_fall_unused)
  );

  sdo_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sck),
    .level_o (sck_lvl_unused),
    .rise_o  (sck_rise),
    .fall_o  (sck_fall)
  );

  sdo_seq_fsm #(.BITS(FRAME_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_hi     (cs_hi),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .conv_done (conv_done),
    .phase_o   (phase),
    .load_o    (load),
    .shift_o   (shift),
    .start_o   (conv_start)
  );

  sdo_frame_shifter #(.W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .frame_i (pack_frame(conv_sign, conv_result)),
    .shift_i (shift),
    .msb_o   (frame_msb)
  );

  assign over_fs_unused = above_full_scale(pack_frame(conv_sign, conv_result));

  always_comb begin
    case (phase)
      PH_CONV:  sdo = 1'b1;
      PH_SLEEP: sdo = 1'b0;
      default:  sdo = frame_msb;
    endcase
  end

  assign sdo_oe = ~cs_hi;

  // R3: an enabled pin during conversion reports busy
  p_busy_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && phase == PH_CONV) |-> sdo);

  // R6: the shifted bit moves only when the clock falls
  p_move_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_SHIFT && phase == PH_SHIFT && !$past(sck_fall)) |-> $stable(sdo));

endmodule

// File: tb/sdo_readout_port_tb.sv
module sdo_readout_port_tb;
  import sdo_port_pkg::*;

  localparam int HALF = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cs_n = 1'b1;
  logic             sck = 1'b0;
  logic             conv_done = 1'b0;
  logic             conv_sign = 1'b0;
  logic [RES_W-1:0] conv_result = '0;
  logic             conv_start, sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int wide_pulses = 0;
  logic prev_start = 1'b0;

  logic  exp_q[$];
  string tag_q[$];
  event  smp_ev;

  always #10 clk = ~clk;

  sdo_readout_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .conv_done(conv_done), .conv_sign(conv_sign), .conv_result(conv_result),
    .conv_start(conv_start), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) starts++;
      if (conv_start && prev_start) wide_pulses++;
      prev_start = conv_start;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] expect_frame(input bit s, input logic [20:0] r);
    return (24'(s) << 21) + 24'(r);
  endfunction

  task automatic convert(input bit s, input logic [20:0] r);
    conv_sign = s; conv_result = r; conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
    tick(3);
  endtask

  // Driver: queue expected bits, then clock them out
  task automatic read_bits(input logic [23:0] f, input int n, input string req);
    logic pre;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(f[23-i]);
      tag_q.push_back(req);
    end
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      -> smp_ev;
      pre = sdo;
      sck = 1'b1;
      tick(4);
      if (i < n - 1) chk(sdo === pre, "R6", "steady after rising edge", 32'(sdo), 32'(pre));
      tick(HALF - 4);
      sck = 1'b0;
      tick(HALF);
    end
  endtask

  // Monitor: pop and compare on each sample point
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected sample", 32'(sdo), 32'hx);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(sdo === e, t, "frame bit", 32'(sdo), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] fa, fb, fc, fd;
    int s0;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    chk(starts == 1, "R1", "start pulse after reset", 32'(starts), 32'd1);
    chk(sdo_oe === 1'b0, "R2", "pin released with cs high", 32'(sdo_oe), 32'd0);

    cs_n = 1'b0; tick(4);
    chk(sdo_oe === 1'b1, "R2", "pin driven with cs low", 32'(sdo_oe), 32'd1);
    chk(sdo === 1'b1, "R1", "busy status after reset", 32'(sdo), 32'd1);
    cs_n = 1'b1; tick(4);

    // R4: capture, then a stray strobe while idle
    fa = expect_frame(1'b1, 21'h0B5A3C);
    convert(1'b1, 21'h0B5A3C);
    convert(1'b0, 21'h1FFFFF);
    chk(starts == 1, "R4", "no start on stray strobe", 32'(starts), 32'd1);
    read_bits(fa, 24, "R4");
    tick(HALF);
    chk(starts == 2, "R7", "start after full frame", 32'(starts), 32'd2);
    chk(sdo === 1'b1, "R3", "busy after full frame", 32'(sdo), 32'd1);
    cs_n = 1'b1; tick(4);
    chk(sdo_oe === 1'b0, "R2", "released after readout", 32'(sdo_oe), 32'd0);

    // R8: chip-select pulse with no clock keeps the frame
    fb = expect_frame(1'b0, 21'h1F0F0F);
    convert(1'b0, 21'h1F0F0F);
    cs_n = 1'b0; tick(6);
    chk(sdo === 1'b0, "R8", "done status shown", 32'(sdo), 32'd0);
    cs_n = 1'b1; tick(6);
    chk(starts == 2, "R8", "no start on early release", 32'(starts), 32'd2);
    read_bits(fb, 24, "R8");
    tick(HALF);
    chk(starts == 3, "R7", "start after second frame", 32'(starts), 32'd3);
    cs_n = 1'b1; tick(4);

    // R9: overrange frame, abandoned after five bits
    fc = expect_frame(1'b1, 21'h100ACE);
    chk(fc[21] && fc[20], "R5", "overrange marker bits", 32'(fc[21:20]), 32'd3);
    convert(1'b1, 21'h100ACE);
    s0 = starts;
    read_bits(fc, 5, "R5");
    cs_n = 1'b1; tick(6);
    chk(starts == s0 + 1, "R9", "start after abort", 32'(starts), 32'(s0 + 1));
    cs_n = 1'b0; tick(5);
    chk(sdo === 1'b1, "R3", "busy after abort", 32'(sdo), 32'd1);
    cs_n = 1'b1; tick(4);

    // New frame after an abort must start from its first bit
    fd = expect_frame(1'b0, 21'h00F00D);
    convert(1'b0, 21'h00F00D);
    read_bits(fd, 24, "R9");
    tick(HALF);
    cs_n = 1'b1; tick(6);

    chk(exp_q.size() == 0, "R5", "all bits sampled", 32'(exp_q.size()), 32'd0);
    chk(wide_pulses == 0, "R10", "start pulse width", 32'(wide_pulses), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule